// File: doc/BRIEF.md
# Pretrigger Capture Sequencer

This block sequences the writes into a circular sample buffer for an on-chip signal recorder. Before a capture starts, the host programs a capture mode and a pretrigger length. It then raises a start request. The sequencer first writes a fixed number of history samples. It then keeps overwriting the ring while it waits for a one-bit match signal from a separate comparator stage. Once the match arrives, it writes exactly enough further samples to fill the ring, and then it halts.

On completion the block publishes the ring address that holds the oldest stored sample. The host reads the buffer from that address, wrapping at the end, and gets the samples in time order. The pretrigger history and the match sample then sit at known offsets. A stop request returns the sequencer to idle from any state, so the host can always recover before the next capture. Two further modes exist. One records only the cycles on which the match signal is high. The other fills the ring at once without looking at the match signal.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, the state output is 0 (idle), write enable is low, and both the read pointer and the write address are 0. The configuration holds mode 0 (one-shot) and a history length of DEPTH/2 until the host changes it.
- R2: A capture starts only on a 0-to-1 transition of `start_req` while the state is idle. A start request that is held high, or that arrives in state 3 (done), does nothing.
- R3: A 0-to-1 transition of `stop_req` blocks the write in that same cycle. The state is 0 on the next cycle, whatever state the block was in.
- R4: State encoding is 0 idle, 1 history fill, 2 armed, 3 done. In mode 0 with history length L > 0, a start is followed by exactly L cycles in state 1 that write every cycle, and then state 2. With L = 0, or in modes 1 and 2, the start leads straight to state 2. The match input is ignored while the state is 1.
- R5: In mode 0, the block writes every cycle in state 2. The first match seen in state 2 begins the final run of exactly DEPTH - L writes, counting the match cycle. After that run, write enable goes low and the state becomes 3.
- R6: In mode 1 (sparse), the block writes in state 2 only on cycles where `trig_i` is 1. After the DEPTH-th write, the state becomes 3.
- R7: In mode 2 (free-run), the block writes on DEPTH consecutive cycles starting at the cycle after the start edge, whatever `trig_i` does and whatever L is. It then enters state 3.
- R8: The write address is 0 for the first write of a capture and advances by one per write. It wraps from DEPTH-1 to 0 and never reaches DEPTH.
- R9: On entry to state 3, the read pointer holds the address that follows the last write. That address holds the oldest sample. The read pointer keeps this value while the state stays 3.
- R10: A configuration write is taken only in the idle state. A mode code of 3 leaves the stored mode unchanged, and a history length of DEPTH or more leaves the stored length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Start request, acted on at its rising edge |
| stop_req | input | 1 | Abort request, acted on at its rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 0 one-shot, 1 sparse, 2 free-run |
| cfg_loc | input | AW | Pretrigger history length L |
| trig_i | input | 1 | Match signal from the comparator stage |
| state_o | output | 2 | Current state (0..3) |
| rd_ptr_o | output | AW | Address of the oldest sample after a capture |
| wr_addr_o | output | AW | Sample buffer write address |
| wr_en_o | output | 1 | Sample buffer write enable |

## Verification
The bench builds the block with DEPTH = 12, a size that is not a power of two. This lets address wrap-around be tested separately from the natural rollover of a 4-bit counter. It also makes 12 and above into history-length codes that the port can carry but the block must refuse. With 12 slots, the extreme history lengths 0 and 11 are cheap to reach. So are a match landing on the very first armed cycle and a match arriving during history fill, and each capture stays within a few dozen cycles. The expected write count, completion cycle and read pointer of every capture follow in closed form from the match cycle and L.

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_loc,
  input  logic          trig_i,
  output logic [1:0]    state_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_en_o
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_FILL = 2'd1, S_ARMED = 2'd2, S_DONE = 2'd3} state_t;

  localparam logic [1:0] M_ONESHOT = 2'd0;
  localparam logic [1:0] M_SPARSE  = 2'd1;
  localparam logic [1:0] M_FREE    = 2'd2;

  state_t        st;
  logic [1:0]    mode_r;
  logic [AW-1:0] loc_r;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          seen, start_q, stop_q;

  logic          start_rise, stop_rise, fire, run_last, fill_last;
  logic [AW-1:0] ptr_next;
  logic [CW-1:0] target;

  assign start_rise = start_req & ~start_q;
  assign stop_rise  = stop_req & ~stop_q;
  assign ptr_next   = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
  assign target     = (mode_r == M_ONESHOT) ? CW'(DEPTH) - CW'(loc_r) : CW'(DEPTH);

  always_comb begin
    fire = 1'b0;
    if (st == S_ARMED) begin
      case (mode_r)
        M_FREE:   fire = 1'b1;
        M_SPARSE: fire = trig_i;
        default:  fire = seen | trig_i;
      endcase
    end
  end

  assign run_last  = fire && (cnt + 1'b1 == target);
  assign fill_last = (st == S_FILL) && (cnt + 1'b1 == CW'(loc_r));
  assign wr_en_o   = ~stop_rise & ((st == S_FILL) |
                     ((st == S_ARMED) & ((mode_r != M_SPARSE) | trig_i)));
  assign state_o   = st;
  assign wr_addr_o = wptr;
  assign rd_ptr_o  = rptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_r  <= M_ONESHOT;
      loc_r   <= AW'(DEPTH / 2);
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      seen    <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_req;
      stop_q  <= stop_req;
      if (cfg_we && st == S_IDLE) begin
        if (cfg_mode != 2'd3) mode_r <= cfg_mode;
        if (32'(cfg_loc) < 32'(DEPTH)) loc_r <= cfg_loc;
      end
      if (wr_en_o) wptr <= ptr_next;
      if (stop_rise) begin
        st   <= S_IDLE;
        seen <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start_rise) begin
            wptr <= '0;
            cnt  <= '0;
            seen <= 1'b0;
            st   <= (mode_r == M_ONESHOT && loc_r != '0) ? S_FILL : S_ARMED;
          end
          S_FILL: begin
            cnt <= cnt + 1'b1;
            if (fill_last) begin
              cnt <= '0;
              st  <= S_ARMED;
            end
          end
          S_ARMED: begin
            if (mode_r == M_ONESHOT && trig_i) seen <= 1'b1;
            if (fire) cnt <= cnt + 1'b1;
            if (run_last) begin
              st   <= S_DONE;
              rptr <= ptr_next;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_DONE) |-> !wr_en_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start_rise) |=> st == S_IDLE);

  p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !stop_rise) |=> st == S_DONE);

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> st == S_IDLE);

  p_fill_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && !stop_rise) |=> (st == S_FILL || st == S_ARMED));

  p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wr_addr_o) < 32'(DEPTH));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == AW'(DEPTH - 1)) |=> wr_addr_o == '0);

  p_rptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !stop_rise) |=> $stable(rd_ptr_o));

endmodule

// File: tb/tb_capture_ctrl.sv
`timescale 1ns/1ps
module tb_capture_ctrl;
  localparam int DEPTH = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n, start_req, stop_req, cfg_we, trig_i;
  logic [1:0] cfg_mode;
  logic [AW-1:0] cfg_loc;
  logic [1:0] state_o;
  logic [AW-1:0] rd_ptr_o, wr_addr_o;
  logic wr_en_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  capture_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_loc(cfg_loc), .trig_i(trig_i),
    .state_o(state_o), .rd_ptr_o(rd_ptr_o), .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o)
  );

  // mode, L, first match cycle, match period, writes, completion cycle, read pointer
  localparam int NV = 8;
  localparam int TV_MODE[NV] = '{0, 0, 0, 0, 0, 2, 1, 1};
  localparam int TV_LOC [NV] = '{6, 3, 0, 11, 8, 5, 0, 7};
  localparam int TV_T   [NV] = '{6, 20, 0, 15, 2, 1000, 1, 3};
  localparam int TV_P   [NV] = '{1000, 1000, 1000, 1000, 10, 1000, 2, 1};
  localparam int TV_W   [NV] = '{12, 29, 12, 16, 16, 12, 12, 12};
  localparam int TV_C   [NV] = '{12, 29, 12, 16, 16, 12, 24, 15};
  localparam int TV_RD  [NV] = '{0, 5, 0, 4, 4, 0, 0, 0};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int m, input int l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m[1:0]; cfg_loc = l[AW-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic abort_pulse();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic run(input int mode, input int L, input int T, input int P, input bit do_cfg,
                     input int exp_w, input int exp_c, input int exp_rd, input bit keep,
                     input string tag);
    int writes = 0;
    int addr_bad = 0;
    int state_bad = 0;
    int capt = -1;
    if (do_cfg) cfg_write(mode, L);
    @(negedge clk); start_req = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start_req = 1'b0;
      trig_i = (k >= T) && (((k - T) % P) == 0);
      #1;
      if (state_o == 2'd3) begin
        capt = k;
        break;
      end
      if (int'(state_o) != ((mode == 0 && k < L) ? 1 : 2)) state_bad++;
      if (wr_en_o) begin
        if (int'(wr_addr_o) != writes % DEPTH) addr_bad++;
        writes++;
      end
    end
    trig_i = 1'b0;
    chk({tag, " write count"}, writes, exp_w);
    chk({tag, " completion cycle"}, capt, exp_c);
    chk("R4 state sequence mismatches", state_bad, 0);
    chk("R8 write address mismatches", addr_bad, 0);
    chk("R9 read pointer", int'(rd_ptr_o), exp_rd);
    if (!keep) abort_pulse();
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_req = 1'b0; stop_req = 1'b0; cfg_we = 1'b0;
    cfg_mode = 2'd0; cfg_loc = '0; trig_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 state", int'(state_o), 0);
    chk("R1 write enable", int'(wr_en_o), 0);
    chk("R1 read pointer", int'(rd_ptr_o), 0);
    chk("R1 write address", int'(wr_addr_o), 0);

    // R1 defaults: one-shot, L = 6
    run(0, 6, 9, 1000, 1'b0, 15, 15, 3, 1'b0, "R1 default config");

    for (int i = 0; i < NV; i++) begin
      run(TV_MODE[i], TV_LOC[i], TV_T[i], TV_P[i], 1'b1, TV_W[i], TV_C[i], TV_RD[i], 1'b0,
          (TV_MODE[i] == 0) ? "R5" : (TV_MODE[i] == 1) ? "R6" : "R7");
    end

    // R10: reserved mode and out-of-range length are refused
    cfg_write(0, 4);
    cfg_write(3, 12);
    run(0, 4, 7, 1000, 1'b0, 15, 15, 3, 1'b1, "R10 refused fields");

    // R10: write while done is refused; R2: start in done ignored
    cfg_write(2, 1);
    @(negedge clk); start_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 start in done state", int'(state_o), 3);
    chk("R9 read pointer held", int'(rd_ptr_o), 3);
    abort_pulse();
    repeat (3) @(negedge clk);
    #1;
    chk("R2 held start after abort", int'(state_o), 0);
    chk("R2 held start no write", int'(wr_en_o), 0);
    @(negedge clk); start_req = 1'b0;
    run(0, 4, 7, 1000, 1'b0, 15, 15, 3, 1'b0, "R10 config kept");

    // R3: abort while armed
    cfg_write(0, 2);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R4 armed after fill", int'(state_o), 2);
    stop_req = 1'b1;
    #1;
    chk("R3 write blocked on abort edge", int'(wr_en_o), 0);
    @(negedge clk);
    #1;
    chk("R3 idle after abort", int'(state_o), 0);
    chk("R3 no write after abort", int'(wr_en_o), 0);
    stop_req = 1'b0;

    // R3: abort during history fill
    cfg_write(0, 9);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    #1;
    chk("R4 fill state", int'(state_o), 1);
    abort_pulse();
    #1;
    chk("R3 idle after abort in fill", int'(state_o), 0);

    run(0, 2, 2, 1000, 1'b1, 12, 12, 0, 1'b0, "R5 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule